// File: doc/BRIEF.md
# Nonvolatile Memory Command Status and Launch Register

This block is the byte-wide status register that software uses to start and monitor commands on a nonvolatile memory controller. It sits on a simple register bus with an address, a write strobe, write data and registered read data. A write with a one in the completion bit starts a command. The block then raises a one-cycle launch pulse toward the controller. It holds the completion bit low until the controller reports that the command has finished or was rejected.

Two error flags report bad command sequences and writes to protected regions. The controller raises each flag with a strobe. Each flag stays set until software writes a one to it. While either flag is set, no command can start. When a command finishes normally, the block latches a two-bit result code from the controller. It clears that code on the next command that does start. A busy bit shows either a running command or background work in the controller. A completion interrupt follows the completion bit, gated by an enable input.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset the register reads 0x80, with only bit 7 (command complete) set. `launch` and `irq` are low after reset.
- R2: Writing a byte with bit 7 set, while bit 7 reads 1 and both error flags are clear, raises `launch` for exactly one cycle. After that write the register reads bit 7 = 0 and bit 3 (busy) = 1.
- R3: A `ctl_done` strobe during a command does three things. It sets bit 7 again, clears bit 3, and copies `ctl_status` into bits 1:0.
- R4: `ctl_acc_viol` sets bit 5, the access-error flag. Only a write with bit 5 = 1 clears it; a write with bit 5 = 0 leaves it set.
- R5: `ctl_prot_viol` sets bit 4, the protection-violation flag. Only a write with bit 4 = 1 clears it; a write with bit 4 = 0 leaves it set.
- R6: While bit 5 or bit 4 is set, a write with bit 7 = 1 does not pulse `launch` and does not clear bit 7. This holds when the same write also clears the error flags: the flags are cleared and the launch is still refused.
- R7: A violation strobe during a command ends the command. Bit 7 returns to 1 and bit 3 to 0.
- R8: Bits 6 and 2 always read 0. Writes have no effect on bits 3, 1 and 0. A write with bit 7 = 0 starts nothing.
- R9: Bit 3 reads 1 while `ctl_bg_busy` is high, even when bit 7 is 1.
- R10: `irq` equals bit 7 AND `irq_en`, one clock cycle later.
- R11: Bits 1:0 return to 0 on the next command that actually starts.
- R12: Writes to any address other than `REG_ADDR` change nothing. Reads of any other address return 0x00. Read data appears one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ctl_done | input | 1 | Controller strobe: command finished |
| ctl_status | input | 2 | Result code, sampled with `ctl_done` |
| ctl_acc_viol | input | 1 | Controller strobe: sequence or access violation |
| ctl_prot_viol | input | 1 | Controller strobe: protection violation |
| ctl_bg_busy | input | 1 | Controller is doing background work |
| irq_en | input | 1 | Completion interrupt enable |
| launch | output | 1 | One-cycle command start pulse |
| irq | output | 1 | Completion interrupt |

## Verification
Each kind of internal fault shows up at the ports within two cycles of the write or strobe that caused it:
- A completion flag stuck in the wrong state shows on the next read. It also changes `irq` one cycle later and either suppresses or repeats `launch`.
- A sticky flag that fails to hold shows on the read after a write of zero.
- A launch check that sees the post-write error state instead of the pre-write state produces a `launch` pulse in the cycle right after a combined clear-and-launch write.
- A stale result code shows on the first read after the next launch.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DATA_W     = 8;
  localparam int STAT_W     = 2;
  localparam int BIT_DONE   = 7;
  localparam int BIT_ACCERR = 5;
  localparam int BIT_PROT   = 4;
  localparam int BIT_BUSY   = 3;
  localparam int N_STICKY   = 2;
  localparam int IDX_ACC    = 0;
  localparam int IDX_PROT   = 1;

  typedef struct packed {
    logic              done;
    logic              accerr;
    logic              prot;
    logic              busy;
    logic [STAT_W-1:0] stat;
  } fcs_view_t;

  function automatic logic [DATA_W-1:0] pack_view(fcs_view_t v);
    logic [DATA_W-1:0] b;
    b              = '0;
    b[BIT_DONE]    = v.done;
    b[BIT_ACCERR]  = v.accerr;
    b[BIT_PROT]    = v.prot;
    b[BIT_BUSY]    = v.busy;
    b[STAT_W-1:0]  = v.stat;
    return b;
  endfunction
endpackage

// File: rtl/fcs_bus_decode.sv
module fcs_bus_decode
  import fcs_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              hit,
  output logic              w1_start,
  output logic [N_STICKY-1:0] w1_clear
);
  logic wr_hit;
  logic unused_wdata;

  assign hit          = (bus_addr == REG_ADDR);
  assign wr_hit       = hit & bus_wr;
  assign w1_start     = wr_hit & bus_wdata[BIT_DONE];
  assign w1_clear[IDX_ACC]  = wr_hit & bus_wdata[BIT_ACCERR];
  assign w1_clear[IDX_PROT] = wr_hit & bus_wdata[BIT_PROT];
  assign unused_wdata = ^{bus_wdata[6], bus_wdata[3:0]};
endmodule

// File: rtl/fcs_sticky.sv
module fcs_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fcs_cmd_ctrl.sv
module fcs_cmd_ctrl
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              w1_start,
  input  logic              blocked,
  input  logic              done_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              viol_i,
  output logic              ccif,
  output logic [STAT_W-1:0] stat,
  output logic              launch
);
  logic go;

  assign go = w1_start & ccif & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccif   <= 1'b1;
      stat   <= '0;
      launch <= 1'b0;
    end else begin
      launch <= go;
      if (go) begin
        ccif <= 1'b0;
        stat <= '0;
      end else if (!ccif && done_i) begin
        ccif <= 1'b1;
        stat <= status_i;
      end else if (!ccif && viol_i) begin
        ccif <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ctl_done,
  input  logic [1:0]        ctl_status,
  input  logic              ctl_acc_viol,
  input  logic              ctl_prot_viol,
  input  logic              ctl_bg_busy,
  input  logic              irq_en,
  output logic              launch,
  output logic              irq
);
  logic                hit;
  logic                w1_start;
  logic [N_STICKY-1:0] w1_clear;
  logic [N_STICKY-1:0] set_vec;
  logic [N_STICKY-1:0] flags;
  logic                accerr;
  logic                fpviol;
  logic                ccif;
  logic [STAT_W-1:0]   stat;
  fcs_view_t           view;

  fcs_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .hit      (hit),
    .w1_start (w1_start),
    .w1_clear (w1_clear)
  );

  assign set_vec[IDX_ACC]  = ctl_acc_viol;
  assign set_vec[IDX_PROT] = ctl_prot_viol;

  fcs_sticky #(.N(N_STICKY)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_vec),
    .clr_i (w1_clear),
    .flag_o(flags)
  );

  assign accerr = flags[IDX_ACC];
  assign fpviol = flags[IDX_PROT];

  fcs_cmd_ctrl u_cmd (
    .clk     (clk),
    .rst     (rst),
    .w1_start(w1_start),
    .blocked (accerr | fpviol),
    .done_i  (ctl_done),
    .status_i(ctl_status),
    .viol_i  (ctl_acc_viol | ctl_prot_viol),
    .ccif    (ccif),
    .stat    (stat),
    .launch  (launch)
  );

  always_comb begin
    view.done   = ccif;
    view.accerr = accerr;
    view.prot   = fpviol;
    view.busy   = ~ccif | ctl_bg_busy;
    view.stat   = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= hit ? pack_view(view) : '0;
      irq       <= ccif & irq_en;
    end
  end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ctl_bg_busy,
  input logic              irq_en,
  input logic              launch,
  input logic              irq,
  input logic [7:0]        bus_rdata,
  input logic              ccif,
  input logic              accerr,
  input logic              fpviol,
  input logic [1:0]        stat
);
  assert_launch_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);

  assert_launch_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
    launch |-> !ccif);

  assert_no_launch_when_flagged_R6: assert property (@(posedge clk) disable iff (rst)
    launch |-> ($past(accerr) == 1'b0 && $past(fpviol) == 1'b0));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[6] == 1'b0 && bus_rdata[2] == 1'b0));

  assert_bg_busy_visible_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_bg_busy && bus_addr == REG_ADDR) |=> bus_rdata[3]);

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(ccif && irq_en)));

  assert_status_cleared_on_start_R11: assert property (@(posedge clk) disable iff (rst)
    launch |-> (stat == 2'b00));

  assert_other_addr_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != REG_ADDR) |=> (bus_rdata == 8'h00));
endmodule

bind flash_cmd_status fcs_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_fcs_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .ctl_bg_busy(ctl_bg_busy),
  .irq_en     (irq_en),
  .launch     (launch),
  .irq        (irq),
  .bus_rdata  (bus_rdata),
  .ccif       (ccif),
  .accerr     (accerr),
  .fpviol     (fpviol),
  .stat       (stat)
);

// File: tb/tb_flash_cmd_status.sv
module tb_flash_cmd_status;
  localparam int          ADDR_W = 4;
  localparam logic [3:0]  RA     = 4'h6;
  localparam logic [3:0]  OTHER  = 4'h2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = RA;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ctl_done = 1'b0;
  logic [1:0] ctl_status = '0;
  logic       ctl_acc_viol = 1'b0;
  logic       ctl_prot_viol = 1'b0;
  logic       ctl_bg_busy = 1'b0;
  logic       irq_en = 1'b0;
  logic       launch;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_status #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_done(ctl_done),
    .ctl_status(ctl_status), .ctl_acc_viol(ctl_acc_viol),
    .ctl_prot_viol(ctl_prot_viol), .ctl_bg_busy(ctl_bg_busy),
    .irq_en(irq_en), .launch(launch), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Write one cycle; returns at the negedge after the capturing edge.
  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = RA;
  endtask

  task automatic pulse_done(logic [1:0] s);
    ctl_done = 1'b1; ctl_status = s;
    @(negedge clk);
    ctl_done = 1'b0; ctl_status = '0;
  endtask

  task automatic pulse_acc();
    ctl_acc_viol = 1'b1; @(negedge clk); ctl_acc_viol = 1'b0;
  endtask

  task automatic pulse_prot();
    ctl_prot_viol = 1'b1; @(negedge clk); ctl_prot_viol = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(RA, v);
    chk("R1 reset value", v, 8'h80);
    chk("R1 launch idle", {7'b0, launch}, 8'h00);
    chk("R1 irq idle", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 irq with enable", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_launch_done();
    logic [7:0] v;
    wr(RA, 8'h80);
    chk("R2 launch pulse", {7'b0, launch}, 8'h01);
    @(negedge clk);
    chk("R2 launch one cycle", {7'b0, launch}, 8'h00);
    chk("R10 irq drops", {7'b0, irq}, 8'h00);
    rd(RA, v);
    chk("R2 running view", v, 8'h08);
    pulse_done(2'b10);
    rd(RA, v);
    chk("R3 done with status", v, 8'h82);
    chk("R10 irq after done", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_status_clear();
    logic [7:0] v;
    wr(RA, 8'h80);
    chk("R11 launch", {7'b0, launch}, 8'h01);
    rd(RA, v);
    chk("R11 status cleared", v, 8'h08);
    pulse_done(2'b01);
    rd(RA, v);
    chk("R3 second status", v, 8'h81);
  endtask

  task automatic t_accerr();
    logic [7:0] v;
    pulse_acc();
    rd(RA, v);
    chk("R4 set", v, 8'hA1);
    wr(RA, 8'h80);
    chk("R6 acc blocks launch", {7'b0, launch}, 8'h00);
    rd(RA, v);
    chk("R6 done stays set", v, 8'hA1);
    wr(RA, 8'h00);
    rd(RA, v);
    chk("R4 write zero keeps", v, 8'hA1);
    wr(RA, 8'hA0);
    chk("R6 combined write refused", {7'b0, launch}, 8'h00);
    @(negedge clk);
    chk("R6 no late launch", {7'b0, launch}, 8'h00);
    rd(RA, v);
    chk("R4 cleared by one", v, 8'h81);
  endtask

  task automatic t_prot();
    logic [7:0] v;
    pulse_prot();
    rd(RA, v);
    chk("R5 set", v, 8'h91);
    wr(RA, 8'h80);
    chk("R6 prot blocks launch", {7'b0, launch}, 8'h00);
    wr(RA, 8'h00);
    rd(RA, v);
    chk("R5 write zero keeps", v, 8'h91);
    wr(RA, 8'h10);
    rd(RA, v);
    chk("R5 cleared by one", v, 8'h81);
  endtask

  task automatic t_viol_during();
    logic [7:0] v;
    wr(RA, 8'h80);
    chk("R7 launch", {7'b0, launch}, 8'h01);
    pulse_prot();
    rd(RA, v);
    chk("R7 violation ends command", v, 8'h90);
    wr(RA, 8'h10);
    rd(RA, v);
    chk("R7 cleared", v, 8'h80);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    wr(RA, 8'h4F);
    chk("R8 no launch", {7'b0, launch}, 8'h00);
    rd(RA, v);
    chk("R8 ro bits unchanged", v, 8'h80);
  endtask

  task automatic t_bg();
    logic [7:0] v;
    ctl_bg_busy = 1'b1;
    rd(RA, v);
    chk("R9 background busy", v, 8'h88);
    ctl_bg_busy = 1'b0;
    rd(RA, v);
    chk("R9 background idle", v, 8'h80);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr(OTHER, 8'h80);
    chk("R12 other addr no launch", {7'b0, launch}, 8'h00);
    rd(RA, v);
    chk("R12 unchanged", v, 8'h80);
    rd(OTHER, v);
    chk("R12 other addr reads zero", v, 8'h00);
    pulse_acc();
    wr(OTHER, 8'h20);
    rd(RA, v);
    chk("R12 other addr no clear", v, 8'hA0);
    wr(RA, 8'h20);
    rd(RA, v);
    chk("R12 restore", v, 8'h80);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_launch_done();
    t_status_clear();
    t_accerr();
    t_prot();
    t_viol_during();
    t_readonly();
    t_bg();
    t_addr();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule